// File: doc/BRIEF.md
# Hysteretic Light-Level Slicer with Gap Filler

This block turns a stream of 8-bit unsigned light-level samples into one clean binary level that reads either "lit" or "dark". Each sample comes with a one-cycle valid strobe. Two programmable thresholds form a hysteresis band. A sample at or above the upper threshold sets the slicer. A sample at or below the lower threshold clears it. A sample inside the band leaves the slicer where it was.

A display that refreshes by scanning makes a lit spot look like a train of short pulses. A plain slicer would report every dark gap between those pulses as a data edge. To prevent this, a retriggerable one-shot is reloaded on every sample that the slicer judges lit. The one-shot then counts down once per sample, and the output stays lit while the count is nonzero. The result is that a pulsed lit level appears as one continuous lit level. The output goes dark only once the slicer is dark and the one-shot has run out.

Downstream logic that measures bit intervals uses the output as its input. If the thresholds are programmed in an unusable order, the block ignores samples and holds its current state.

Top module: `hyst_gap_slicer`

## Requirements
- R1: A synchronous active-high reset drives the output `lit` to 0 and clears the one-shot count. After reset, a sample below the upper threshold leaves `lit` at 0.
- R2: When a valid sample is greater than or equal to `thr_on`, `lit` is 1 from the clock edge that captures the strobe.
- R3: When a valid sample is less than or equal to `thr_off` and the one-shot count reaches 0 on that sample, `lit` becomes 0 on the same edge. `lit` never falls while the slicer is lit or the count is nonzero.
- R4: A valid sample strictly between `thr_off` and `thr_on` leaves the slicer state unchanged, whether that state is lit or dark.
- R5: Each lit-judged sample loads the count with `hold_len`. With `hold_len` = L ≥ 1, `lit` stays 1 through the next L-1 dark samples and falls on the L-th dark sample.
- R6: A lit-judged sample that arrives while the count is running reloads the full `hold_len`, which restarts the bridging window.
- R7: When `thr_on` is not greater than `thr_off` (this includes equal values), valid samples are ignored. The output, the slicer and the count all stay frozen.
- R8: Clock cycles without `smp_vld` change neither the output nor the count. The countdown advances only on valid samples.
- R9: With `hold_len` = 0, `lit` follows the slicer directly and falls on the first dark sample.
- R10: `hold_len` is sampled only when a reload happens. Changing it during a countdown does not affect the count already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | One-cycle strobe marking a new sample |
| smp_lvl | input | 8 | Unsigned light level |
| thr_on | input | 8 | Upper threshold; a sample at or above it counts as lit |
| thr_off | input | 8 | Lower threshold; a sample at or below it counts as dark |
| hold_len | input | 8 | One-shot reload value, counted in samples |
| lit | output | 1 | Registered level: 1 = illuminated, 0 = dark |

## Verification
The only visible state is the one-shot count and the slicer bit, and both show up at `lit` solely through the exact sample on which the output falls. A count that is off by one, does not reload, or moves on idle cycles therefore shows at the port only as a fall that comes one sample early or late. The directed tests count dark samples after a known reload so that each such error moves the falling edge to a sample index that the checks inspect. A slicer that ignores the hysteresis band or the threshold-order guard shows up on the very next strobe, as a level change that should not happen.

// File: rtl/slicer_pkg.sv
package slicer_pkg;
  typedef enum logic [1:0] {
    SL_HOLD = 2'd0,
    SL_SET  = 2'd1,
    SL_CLR  = 2'd2
  } slice_act_e;
endpackage

// File: rtl/lvl_slicer.sv
module lvl_slicer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         smp_vld,
  input  logic [W-1:0] smp_lvl,
  input  logic [W-1:0] thr_on,
  input  logic [W-1:0] thr_off,
  output logic         take,
  output logic         raw_d,
  output logic         raw_q
);
  import slicer_pkg::*;

  function automatic logic band_ok(input logic [W-1:0] hi, input logic [W-1:0] lo);
    return hi > lo;
  endfunction

  function automatic slice_act_e classify(input logic [W-1:0] v,
                                          input logic [W-1:0] hi,
                                          input logic [W-1:0] lo);
    if (v >= hi) return SL_SET;
    if (v <= lo) return SL_CLR;
    return SL_HOLD;
  endfunction

  slice_act_e act;
  logic       cfg_ok;

  assign cfg_ok = band_ok(thr_on, thr_off);
  assign take   = smp_vld && cfg_ok;
  assign act    = classify(smp_lvl, thr_on, thr_off);

  always_comb begin
    raw_d = raw_q;
    if (take) begin
      case (act)
        SL_SET:  raw_d = 1'b1;
        SL_CLR:  raw_d = 1'b0;
        default: raw_d = raw_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) raw_q <= 1'b0;
    else     raw_q <= raw_d;
  end

  // R2: a sample at or above the upper threshold sets the slicer
  p_set_r2: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && (thr_on > thr_off) && (smp_lvl >= thr_on)) |=> raw_q);

  // R4: a sample inside the band keeps the slicer state
  p_band_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && (smp_lvl > thr_off) && (smp_lvl < thr_on)) |=> $stable(raw_q));

  // R7: an unusable threshold order freezes the slicer
  p_cfg_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    (thr_on <= thr_off) |=> $stable(raw_q));
endmodule

// File: rtl/gap_oneshot.sv
module gap_oneshot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         take,
  input  logic         fire,
  input  logic [W-1:0] hold_len,
  output logic [W-1:0] cnt_q,
  output logic         busy_d
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  function automatic logic [W-1:0] step(input logic [W-1:0] c);
    return (c == ZERO) ? ZERO : c - ONE;
  endfunction

  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (fire)      cnt_d = hold_len;
    else if (take) cnt_d = step(cnt_q);
  end

  assign busy_d = (cnt_d != ZERO);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= ZERO;
    else     cnt_q <= cnt_d;
  end

  // R5 / R6: every lit-judged sample loads the full reload value
  p_reload_r6: assert property (@(posedge clk) disable iff (rst)
    fire |=> (cnt_q == $past(hold_len)));

  // R5: a dark sample takes exactly one step off a running count
  p_countdown_r5: assert property (@(posedge clk) disable iff (rst)
    (take && !fire && (cnt_q != ZERO)) |=> (cnt_q == $past(cnt_q) - ONE));

  // R8: without an accepted sample the count holds
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(cnt_q));
endmodule

// File: rtl/hyst_gap_slicer.sv
module hyst_gap_slicer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         smp_vld,
  input  logic [W-1:0] smp_lvl,
  input  logic [W-1:0] thr_on,
  input  logic [W-1:0] thr_off,
  input  logic [W-1:0] hold_len,
  output logic         lit
);
  logic         take;
  logic         raw_d;
  logic         raw_q;
  logic         fire;
  logic         busy_d;
  logic [W-1:0] cnt_q;
  logic         lit_q;

  lvl_slicer #(.W(W)) u_slice (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_lvl(smp_lvl),
    .thr_on(thr_on), .thr_off(thr_off),
    .take(take), .raw_d(raw_d), .raw_q(raw_q)
  );

  assign fire = take && raw_d;

  gap_oneshot #(.W(W)) u_shot (
    .clk(clk), .rst(rst), .take(take), .fire(fire),
    .hold_len(hold_len), .cnt_q(cnt_q), .busy_d(busy_d)
  );

  always_ff @(posedge clk) begin
    if (rst)       lit_q <= 1'b0;
    else if (take) lit_q <= raw_d || busy_d;
  end

  assign lit = lit_q;

  // R3: the output falls only with the slicer dark and the count empty
  p_fall_clean_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(lit_q) |-> (!raw_q && (cnt_q == '0)));

  // R5: a running count always shows as lit
  p_busy_lit_r5: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> lit_q);

  // R8: idle cycles leave the output alone
  p_idle_out_r8: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> $stable(lit_q));

  // R1: reset clears the output
  p_reset_r1: assert property (@(posedge clk)
    rst |=> !lit_q);
endmodule

// File: tb/sim_hyst_gap_slicer.sv
module sim_hyst_gap_slicer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       smp_vld = 1'b0;
  logic [7:0] smp_lvl = 8'd0;
  logic [7:0] thr_on = 8'd100;
  logic [7:0] thr_off = 8'd50;
  logic [7:0] hold_len = 8'd0;
  logic       lit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hyst_gap_slicer u0 (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_lvl(smp_lvl),
    .thr_on(thr_on), .thr_off(thr_off), .hold_len(hold_len), .lit(lit)
  );

  task automatic check(input string req, input logic exp);
    checks++;
    if (lit !== exp) begin
      errors++;
      $display("FAIL %s lit=%b expected=%b", req, lit, exp);
    end
  endtask

  task automatic give(input logic [7:0] v);
    @(negedge clk);
    smp_vld = 1'b1;
    smp_lvl = v;
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 after reset", 1'b0);
    thr_on = 100; thr_off = 50; hold_len = 5;
    give(8'd150); check("R2 set before mid reset", 1'b1);
    do_reset();
    check("R1 mid-run reset", 1'b0);
    give(8'd80); check("R1 band after reset", 1'b0);
    give(8'd10); check("R1 count cleared", 1'b0);
  endtask

  task automatic t_slice();
    do_reset();
    thr_on = 100; thr_off = 50; hold_len = 0;
    give(8'd100); check("R2 at upper threshold", 1'b1);
    give(8'd99);  check("R4 band keeps lit", 1'b1);
    give(8'd50);  check("R3 at lower threshold", 1'b0);
    give(8'd51);  check("R4 band keeps dark", 1'b0);
    give(8'd99);  check("R4 band top keeps dark", 1'b0);
    give(8'd255); check("R2 full scale", 1'b1);
    give(8'd0);   check("R3 zero level", 1'b0);
  endtask

  task automatic t_gap();
    do_reset();
    thr_on = 100; thr_off = 50; hold_len = 3;
    give(8'd150); check("R5 set", 1'b1);
    give(8'd10);  check("R5 dark 1 bridged", 1'b1);
    give(8'd10);  check("R5 dark 2 bridged", 1'b1);
    give(8'd10);  check("R5 dark 3 falls", 1'b0);
  endtask

  task automatic t_retrig();
    do_reset();
    thr_on = 100; thr_off = 50; hold_len = 3;
    give(8'd150); give(8'd10); give(8'd10);
    check("R6 still bridged", 1'b1);
    give(8'd150); check("R6 retrigger", 1'b1);
    give(8'd10);  check("R6 dark 1", 1'b1);
    give(8'd10);  check("R6 dark 2", 1'b1);
    give(8'd10);  check("R6 dark 3 falls", 1'b0);
  endtask

  task automatic t_idle();
    do_reset();
    thr_on = 100; thr_off = 50; hold_len = 3;
    give(8'd150);
    smp_lvl = 8'd0;
    for (int i = 0; i < 20; i++) @(negedge clk);
    check("R8 idle keeps lit", 1'b1);
    give(8'd10); check("R8 count not drained", 1'b1);
    give(8'd10); check("R8 count not drained 2", 1'b1);
    give(8'd10); check("R8 falls on schedule", 1'b0);
  endtask

  task automatic t_cfg();
    do_reset();
    thr_on = 100; thr_off = 50; hold_len = 2;
    give(8'd150); check("R7 set", 1'b1);
    thr_on = 50; thr_off = 100;
    give(8'd10); give(8'd10); give(8'd10);
    check("R7 reversed order ignored", 1'b1);
    thr_on = 100; thr_off = 50;
    give(8'd10); check("R7 count frozen", 1'b1);
    give(8'd10); check("R7 falls after restore", 1'b0);
    thr_on = 80; thr_off = 80;
    give(8'd200); check("R7 equal thresholds ignored", 1'b0);
  endtask

  task automatic t_zero();
    do_reset();
    thr_on = 100; thr_off = 50; hold_len = 0;
    give(8'd150); check("R9 set", 1'b1);
    give(8'd10);  check("R9 immediate fall", 1'b0);
  endtask

  task automatic t_len();
    do_reset();
    thr_on = 100; thr_off = 50; hold_len = 2;
    give(8'd150);
    hold_len = 5;
    give(8'd10); check("R10 old length dark 1", 1'b1);
    give(8'd10); check("R10 old length falls", 1'b0);
    give(8'd150);
    hold_len = 1;
    for (int i = 1; i <= 4; i++) begin
      give(8'd10); check("R10 new length bridged", 1'b1);
    end
    give(8'd10); check("R10 new length falls", 1'b0);
  endtask

  initial begin
    t_reset();
    t_slice();
    t_gap();
    t_retrig();
    t_idle();
    t_cfg();
    t_zero();
    t_len();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule